// File: doc/BRIEF.md
# Dual-Rail Start-Up Sequencer

This block is the digital controller that powers up two regulator channels, called A and B, each with its own enable input. While both enables are low it stays in a shutdown state and drives nothing. When either enable goes high, it waits for an undervoltage-lockout decision with hysteresis. That decision is built from two comparator flags: one for the supply being above the upper threshold and one for it being below the lower threshold. Once the supply is good, the controller steps through five shared bring-up phases in a fixed order. Each phase waits for a done handshake, and a phase that never finishes is cut short by a timeout that raises a fault.

After the last phase, the block drives a run enable for each channel. Channel A always has priority. Channel B waits for A to reach its target if A is enabled before B's ramp has begun. B keeps running if its ramp had already begun when A was enabled. A supply drop below the lower threshold stops both channels at once. When the supply recovers, the whole bring-up sequence runs again without any outside action.

Top module: `rail_startup_seq`

## Requirements
- R1: Out of reset, and one cycle after any edge at which both enables are sampled low, `in_shutdown` is 1 and `run_en`, `phase_act` and `seq_fault` are all 0.
- R2: The supply-good decision becomes 1 when `sup_above_hi` is sampled high and 0 when `sup_below_lo` is sampled high (low wins). With both flags low it keeps its value. No phase starts while it is 0.
- R3: `phase_act` is one-hot while bring-up runs. Bit 0 is trim latch, bit 1 bandgap, bit 2 reference, bit 3 bias current and bit 4 bypass fast-charge, taken in that order. The sequence advances one phase at each edge where `phase_done` is high.
- R4: If `phase_done` stays low for `TMO_CYCLES` edges within one phase, `seq_fault` becomes 1 and `phase_act` clears. The fault holds while either enable is high and clears only through shutdown.
- R5: At the edge that completes the last phase, `run_en[0]` (channel A) becomes 1 if `en_a` is high. `run_en[0]` then follows `en_a`.
- R6: If A is enabled and B is enabled before A reaches its target, `run_en[1]` stays 0. It becomes 1 at the edge where `run_en[0]` and `a_on_target` are both high.
- R7: If B is running but `ramp_begun_b` is low when `en_a` is sampled high, `run_en[1]` drops at that same edge while `run_en[0]` rises. B resumes once A reaches its target.
- R8: If `ramp_begun_b` is high when `en_a` rises, `run_en[0]` rises at that edge and `run_en[1]` stays 1.
- R9: If both enables rise in the same cycle, only `run_en[0]` is set at release. `run_en[1]` follows when A reaches its target.
- R10: An edge with `sup_below_lo` high clears both `run_en` bits and `phase_act` at that edge. A later `sup_above_hi` restarts the sequence at phase bit 0.
- R11: When one enable falls while the other stays high, only that channel's `run_en` drops. If A is dropped while B is waiting for it, B starts at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_a | input | 1 | Enable for channel A (priority channel) |
| en_b | input | 1 | Enable for channel B |
| sup_above_hi | input | 1 | Supply comparator: above upper threshold |
| sup_below_lo | input | 1 | Supply comparator: below lower threshold |
| phase_done | input | 1 | Done handshake for the active phase |
| ramp_begun_b | input | 1 | Channel B output ramp has started |
| a_on_target | input | 1 | Channel A output has reached its target |
| phase_act | output | 5 | One-hot active bring-up phase |
| run_en | output | 2 | Run enables, bit 0 channel A, bit 1 channel B |
| in_shutdown | output | 1 | Block is in the shutdown state |
| seq_fault | output | 1 | A phase timed out |

## Verification
The assertions assume that the two supply flags reflect a single comparator with hysteresis, so they are never high in the same cycle. They also assume that `a_on_target` and `ramp_begun_b` are meaningful only while the matching channel is running. The stimulus pulses each supply flag alone and keeps both handshake flags low whenever it sets up a deferral case. `phase_done` is held high only for as many cycles as the phases it means to complete.

// File: rtl/rseq_pkg.sv
// Shared types for the dual-rail start-up sequencer.
// Assumes: five bring-up phases in a fixed order.
package rseq_pkg;
    localparam int NPH = 5;
    localparam int PW  = $clog2(NPH);

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_WAIT  = 3'd1,
        ST_PHASE = 3'd2,
        ST_READY = 3'd3,
        ST_FAULT = 3'd4
    } seq_st_t;
endpackage

// File: rtl/rseq_uvlo.sv
// Undervoltage lockout with hysteresis built from two comparator flags.
// Does: keeps a supply-good bit that the low flag clears and the high flag sets.
// Assumes: the two flags never rise together; if they do, low wins.
module rseq_uvlo (
    input  logic clk,
    input  logic rst_n,
    input  logic above_hi,
    input  logic below_lo,
    output logic ok_nxt
);
    logic ok_q;

    // Next supply-good value: drop wins, rise sets, otherwise hold.
    always_comb begin
        if (below_lo)      ok_nxt = 1'b0;
        else if (above_hi) ok_nxt = 1'b1;
        else               ok_nxt = ok_q;
    end

    // Supply-good register.
    always_ff @(posedge clk) begin
        if (!rst_n) ok_q <= 1'b0;
        else        ok_q <= ok_nxt;
    end

    // Between the thresholds the decision keeps its previous value.
    assert_hyst_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!above_hi && !below_lo) |=> (ok_q == $past(ok_q)));
endmodule

// File: rtl/rseq_core.sv
// Shared bring-up controller: shutdown, supply wait, phase walk, ready, fault.
// Does: walks the one-hot phases on done handshakes, times out each phase.
// Assumes: the supply-good value is given as the value it will hold next.
module rseq_core
    import rseq_pkg::*;
#(
    parameter int TMO_CYCLES = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           any_en,
    input  logic           sup_ok_nxt,
    input  logic           phase_done,
    output logic [NPH-1:0] phase_act,
    output logic           ready_nxt,
    output logic           in_shutdown,
    output logic           seq_fault
);
    localparam int CW = (TMO_CYCLES > 1) ? $clog2(TMO_CYCLES) : 1;

    seq_st_t         st_q, st_d;
    logic [PW-1:0]   idx_q, idx_d;
    logic [CW-1:0]   cnt_q, cnt_d;

    // Next-state selection, ordered by precedence.
    always_comb begin
        st_d  = st_q;
        idx_d = idx_q;
        cnt_d = cnt_q;
        if (!any_en) begin
            st_d  = ST_OFF;
            idx_d = '0;
            cnt_d = '0;
        end else if (st_q == ST_FAULT) begin
            st_d = ST_FAULT;
        end else if (!sup_ok_nxt) begin
            st_d  = ST_WAIT;
            idx_d = '0;
            cnt_d = '0;
        end else begin
            case (st_q)
                ST_OFF, ST_WAIT: begin
                    st_d  = ST_PHASE;
                    idx_d = '0;
                    cnt_d = '0;
                end
                ST_PHASE: begin
                    if (phase_done) begin
                        cnt_d = '0;
                        if (idx_q == PW'(NPH - 1)) st_d = ST_READY;
                        else                       idx_d = idx_q + 1'b1;
                    end else if (cnt_q == CW'(TMO_CYCLES - 1)) begin
                        st_d = ST_FAULT;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: st_d = st_q;
            endcase
        end
    end

    // State, phase index and timeout counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_OFF;
            idx_q <= '0;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            idx_q <= idx_d;
            cnt_q <= cnt_d;
        end
    end

    // One decode per phase strobe.
    for (genvar g = 0; g < NPH; g++) begin : g_strobe
        assign phase_act[g] = (st_q == ST_PHASE) && (idx_q == PW'(g));
    end

    assign ready_nxt   = (st_d == ST_READY);
    assign in_shutdown = (st_q == ST_OFF);
    assign seq_fault   = (st_q == ST_FAULT);

    assert_phase_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(phase_act));

    assert_fault_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_fault && any_en) |=> seq_fault);

    assert_phase_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_act[0] && phase_done && any_en && sup_ok_nxt) |=> phase_act[1]);
endmodule

// File: rtl/rseq_chan_arb.sv
// Channel release arbiter for two rails with A-before-B ordering.
// Does: sets run enables once bring-up is complete, defers B behind A
// unless B's ramp has already begun.
// Assumes: a_on_target and ramp_begun_b are meaningful only while the
// matching channel runs.
module rseq_chan_arb (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ready_nxt,
    input  logic       en_a,
    input  logic       en_b,
    input  logic       ramp_begun_b,
    input  logic       a_on_target,
    output logic [1:0] run_en
);
    logic [1:0] run_q, run_d;
    logic       a_done_q, a_done_d;
    logic       a_reached;

    // Next run enables and the sticky "A has reached target" flag.
    always_comb begin
        a_reached = a_done_q || (run_q[0] && a_on_target);
        run_d[0]  = ready_nxt && en_a;
        run_d[1]  = ready_nxt && en_b &&
                    (!en_a || a_reached || (run_q[1] && ramp_begun_b));
        a_done_d  = run_d[0] && a_reached;
    end

    // Run enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 2'b00;
            a_done_q <= 1'b0;
        end else begin
            run_q    <= run_d;
            a_done_q <= a_done_d;
        end
    end

    assign run_en = run_q;

    // B may only start when A is off or A had reached its target.
    assert_b_after_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_q[1]) |-> ($past(!en_a) || $past(run_q[0] && a_on_target) || $past(a_done_q)));

    // A enabled on a ready rail starts on the next edge.
    assert_a_starts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_nxt && en_a) |=> run_q[0]);
endmodule

// File: rtl/rail_startup_seq.sv
// Dual-rail start-up sequencer top.
// Does: joins the supply lockout, the shared phase controller and the
// channel arbiter.
// Assumes: all inputs are synchronous to clk.
module rail_startup_seq
    import rseq_pkg::*;
#(
    parameter int TMO_CYCLES = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en_a,
    input  logic           en_b,
    input  logic           sup_above_hi,
    input  logic           sup_below_lo,
    input  logic           phase_done,
    input  logic           ramp_begun_b,
    input  logic           a_on_target,
    output logic [NPH-1:0] phase_act,
    output logic [1:0]     run_en,
    output logic           in_shutdown,
    output logic           seq_fault
);
    logic sup_ok_nxt;
    logic ready_nxt;

    rseq_uvlo u_uvlo (
        .clk      (clk),
        .rst_n    (rst_n),
        .above_hi (sup_above_hi),
        .below_lo (sup_below_lo),
        .ok_nxt   (sup_ok_nxt)
    );

    rseq_core #(.TMO_CYCLES(TMO_CYCLES)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .any_en      (en_a || en_b),
        .sup_ok_nxt  (sup_ok_nxt),
        .phase_done  (phase_done),
        .phase_act   (phase_act),
        .ready_nxt   (ready_nxt),
        .in_shutdown (in_shutdown),
        .seq_fault   (seq_fault)
    );

    rseq_chan_arb u_arb (
        .clk          (clk),
        .rst_n        (rst_n),
        .ready_nxt    (ready_nxt),
        .en_a         (en_a),
        .en_b         (en_b),
        .ramp_begun_b (ramp_begun_b),
        .a_on_target  (a_on_target),
        .run_en       (run_en)
    );

    assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_shutdown |-> (run_en == 2'b00 && phase_act == '0));

    assert_uvlo_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sup_below_lo |=> (run_en == 2'b00 && phase_act == '0));
endmodule

// File: tb/rail_startup_seq_test.sv
module rail_startup_seq_test;
    localparam int TMO = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_a = 0, en_b = 0, sup_above_hi = 0, sup_below_lo = 0;
    logic phase_done = 0, ramp_begun_b = 0, a_on_target = 0;
    logic [4:0] phase_act;
    logic [1:0] run_en;
    logic       in_shutdown, seq_fault;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    rail_startup_seq #(.TMO_CYCLES(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .en_a(en_a), .en_b(en_b),
        .sup_above_hi(sup_above_hi), .sup_below_lo(sup_below_lo),
        .phase_done(phase_done), .ramp_begun_b(ramp_begun_b),
        .a_on_target(a_on_target), .phase_act(phase_act), .run_en(run_en),
        .in_shutdown(in_shutdown), .seq_fault(seq_fault)
    );

    // Behavioural reference: 0 off, 1 wait, 2 phase, 3 ready, 4 fault.
    int m_st = 0, m_ph = 0, m_cnt = 0;
    bit m_ok = 0, m_ra = 0, m_rb = 0, m_ad = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_ph = 0; m_cnt = 0; m_ok = 0; m_ra = 0; m_rb = 0; m_ad = 0;
        end else begin
            bit okn, reach, ran, rbn;
            int nst;
            okn = sup_below_lo ? 1'b0 : (sup_above_hi ? 1'b1 : m_ok);
            nst = m_st;
            if (!(en_a || en_b)) begin nst = 0; m_ph = 0; m_cnt = 0; end
            else if (m_st == 4) nst = 4;
            else if (!okn) begin nst = 1; m_ph = 0; m_cnt = 0; end
            else if (m_st <= 1) begin nst = 2; m_ph = 0; m_cnt = 0; end
            else if (m_st == 2) begin
                if (phase_done) begin
                    m_cnt = 0;
                    if (m_ph == 4) nst = 3; else m_ph++;
                end else if (m_cnt == TMO - 1) nst = 4;
                else m_cnt++;
            end
            reach = m_ad || (m_ra && a_on_target);
            ran = (nst == 3) && en_a;
            rbn = (nst == 3) && en_b && (!en_a || reach || (m_rb && ramp_begun_b));
            m_ad = ran && reach;
            m_ra = ran; m_rb = rbn; m_st = nst; m_ok = okn;
        end
    end

    // Cycle-by-cycle comparison against the reference, away from the edge.
    always @(negedge clk) begin
        if (rst_n) begin
            logic [4:0] eph;
            logic [1:0] erun;
            eph  = (m_st == 2) ? (5'b1 << m_ph) : 5'b0;
            erun = {m_rb, m_ra};
            checks++;
            if (phase_act !== eph || run_en !== erun ||
                in_shutdown !== (m_st == 0) || seq_fault !== (m_st == 4)) begin
                errors++;
                $display("FAIL %s model: ph=%b run=%b sd=%b flt=%b exp ph=%b run=%b sd=%0d flt=%0d",
                         cur_req, phase_act, run_en, in_shutdown, seq_fault,
                         eph, erun, m_st == 0, m_st == 4);
            end
        end
    end

    task automatic tick(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic expect_val(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        expect_val("R1", {4'b0, in_shutdown, seq_fault, run_en}, 8'b0000_1000);
        expect_val("R1", {3'b0, phase_act}, 8'h00);

        // R2 enable with no supply-good: no phase starts
        cur_req = "R2"; en_a = 1; tick(4);
        expect_val("R2", {3'b0, phase_act}, 8'h00);
        expect_val("R2", {7'b0, in_shutdown}, 8'h00);

        // R3 phase walk
        cur_req = "R3"; sup_above_hi = 1; tick(1);
        expect_val("R3", {3'b0, phase_act}, 8'b0000_0001);
        sup_above_hi = 0; phase_done = 1; tick(1);
        expect_val("R3", {3'b0, phase_act}, 8'b0000_0010);
        tick(1);
        expect_val("R3", {3'b0, phase_act}, 8'b0000_0100);
        tick(3); phase_done = 0;
        // R5 A released when bring-up ends
        expect_val("R5", {6'b0, run_en}, 8'b01);

        // R6 B held until A reaches target
        cur_req = "R6"; en_b = 1; tick(3);
        expect_val("R6", {6'b0, run_en}, 8'b01);
        a_on_target = 1; tick(1);
        expect_val("R6", {6'b0, run_en}, 8'b11);

        // R11 A falls: only A drops
        cur_req = "R11"; en_a = 0; a_on_target = 0; tick(2);
        expect_val("R11", {6'b0, run_en}, 8'b10);

        // R10 supply drop and automatic rerun
        cur_req = "R10"; sup_below_lo = 1; tick(1);
        expect_val("R10", {1'b0, phase_act, run_en}, 8'h00);
        sup_below_lo = 0; tick(2);
        expect_val("R10", {1'b0, phase_act, run_en}, 8'h00);
        sup_above_hi = 1; tick(1);
        expect_val("R10", {3'b0, phase_act}, 8'b0000_0001);
        sup_above_hi = 0; phase_done = 1; tick(6); phase_done = 0;
        expect_val("R10", {6'b0, run_en}, 8'b10);

        // R7 A arrives before B's ramp began: B withdrawn, A first
        cur_req = "R7"; en_a = 1; tick(1);
        expect_val("R7", {6'b0, run_en}, 8'b01);
        a_on_target = 1; tick(1);
        expect_val("R7", {6'b0, run_en}, 8'b11);

        // R8 A arrives after B's ramp began: both run
        cur_req = "R8"; en_a = 0; a_on_target = 0; tick(2);
        expect_val("R11", {6'b0, run_en}, 8'b10);
        ramp_begun_b = 1; en_a = 1; tick(1);
        expect_val("R8", {6'b0, run_en}, 8'b11);

        // R1 both low -> shutdown
        cur_req = "R1"; en_a = 0; en_b = 0; ramp_begun_b = 0; tick(1);
        expect_val("R1", {4'b0, in_shutdown, seq_fault, run_en}, 8'b0000_1000);

        // R9 simultaneous enables: A first
        cur_req = "R9"; en_a = 1; en_b = 1; phase_done = 1; tick(7); phase_done = 0;
        expect_val("R9", {6'b0, run_en}, 8'b01);
        a_on_target = 1; tick(1);
        expect_val("R9", {6'b0, run_en}, 8'b11);

        // R4 timeout fault, sticky
        cur_req = "R4"; en_a = 0; en_b = 0; a_on_target = 0; tick(2);
        en_b = 1; tick(TMO + 4);
        expect_val("R4", {1'b0, phase_act, seq_fault, run_en}, 8'b0000_0100);
        en_a = 1; tick(2);
        expect_val("R4", {7'b0, seq_fault}, 8'h01);
        en_a = 0; en_b = 0; tick(1);
        expect_val("R4", {6'b0, in_shutdown, seq_fault}, 8'b10);

        // R2 hysteresis: after a low flag, nothing starts until the high flag
        cur_req = "R2"; sup_below_lo = 1; tick(1); sup_below_lo = 0;
        en_a = 1; tick(5);
        expect_val("R2", {3'b0, phase_act}, 8'h00);
        sup_above_hi = 1; tick(1); sup_above_hi = 0;
        expect_val("R2", {3'b0, phase_act}, 8'b0000_0001);
        tick(2);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule